// File: doc/BRIEF.md
# Eight-Entry Serial Word FIFO With Wrapping Level Field

This block is a small first-in first-out store for the transmit and receive paths of a serial controller. It holds up to eight 9-bit words. Its occupancy is reported through a 3-bit level field. Because three bits cannot show eight, a full store reports a level of 0. A full flag and a data-available flag are therefore set alongside the field, so software can tell full apart from empty. When the available flag is set and the level reads 0, software counts eight words.

The block also provides a half-full flag, a transmit-idle flag and a soft reset. The transmit-idle flag takes the state of the external shifter into account. The soft reset only acts on an empty store. When words are still unread, the soft reset is refused and a sticky busy error is raised, so software has to drain the store first. Reads are show-ahead: the oldest word is always present on the output, and a pop strobe moves on to the next word at the clock edge.

Top module: `wrap_level_fifo`

## Requirements
- R1: After the asynchronous reset the store is empty: `level`=0, `empty`=1, `avail`=0, `full`=0, `half`=0 and `busy_err`=0.
- R2: Words leave on `pop_data` in the order they were pushed. `pop_data` shows the oldest stored word, and a pop takes effect at the next rising edge.
- R3: A push while `full`=1 without a pop in the same cycle is ignored: the occupancy and the head word are unchanged.
- R4: A pop while `empty`=1 is ignored and the store stays empty. `avail` is the inverse of `empty`.
- R5: When a push and a pop in the same cycle are both accepted, the occupancy is unchanged. This includes the full case, where the pop frees the slot for the push. On an empty store only the push is accepted.
- R6: `level` is the occupancy modulo 8, so it reads 0 at 8 entries. At 8 entries `full`=1 and `avail`=1.
- R7: `half`=1 exactly when the occupancy is 4 or more.
- R8: `tx_idle`=1 exactly when the store is empty and `shift_busy`=0.
- R9: `soft_rst` takes priority over push and pop in its cycle. On an empty store it clears the store and clears `busy_err`. On a non-empty store the contents are left unchanged and `busy_err` is set.
- R10: `busy_err` stays set until a soft reset is applied to an empty store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset request, synchronous |
| push | input | 1 | Write strobe |
| push_data | input | 9 | Word to store |
| pop | input | 1 | Read strobe |
| shift_busy | input | 1 | External shifter still sending a word |
| pop_data | output | 9 | Oldest stored word |
| level | output | 3 | Occupancy modulo 8 |
| full | output | 1 | Eight words stored |
| half | output | 1 | Four or more words stored |
| empty | output | 1 | No words stored |
| avail | output | 1 | At least one word stored |
| tx_idle | output | 1 | Empty and shifter idle |
| busy_err | output | 1 | Sticky: soft reset refused |

## Verification
The store is taken through short push-then-pop bursts and a full fill to eight, which checks word order and shows whether the level field wraps to 0 while `full` and `avail` mark the difference from empty. Pushes into a full store and pops from an empty one separate a correct overflow and underflow guard from one that moves a pointer. Simultaneous push and pop are tried on an empty, a partly filled and a full store, so each of the three accept rules is exercised. Soft resets are applied to a loaded store, to an empty one and together with push strobes, which separates refusal from clearing and checks that the soft reset takes priority over push and pop.

// File: rtl/wlf_pkg.sv
package wlf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_BOTH,
    OP_CLEAR,
    OP_REFUSE
  } fifo_op_e;
endpackage

// File: rtl/wlf_ctrl.sv
module wlf_ctrl
  import wlf_pkg::*;
(
  input  logic     push_i,
  input  logic     pop_i,
  input  logic     soft_rst_i,
  input  logic     is_empty_i,
  input  logic     is_full_i,
  output fifo_op_e op_o,
  output logic     wr_en_o,
  output logic     rd_en_o,
  output logic     clr_o
);
  logic take_pop;
  logic take_push;

  always_comb begin
    take_pop  = pop_i && !is_empty_i;
    take_push = push_i && (!is_full_i || take_pop);
    if (soft_rst_i) begin
      op_o = is_empty_i ? OP_CLEAR : OP_REFUSE;
    end else if (take_push && take_pop) begin
      op_o = OP_BOTH;
    end else if (take_push) begin
      op_o = OP_PUSH;
    end else if (take_pop) begin
      op_o = OP_POP;
    end else begin
      op_o = OP_IDLE;
    end
    wr_en_o = (op_o == OP_PUSH) || (op_o == OP_BOTH);
    rd_en_o = (op_o == OP_POP)  || (op_o == OP_BOTH);
    clr_o   = (op_o == OP_CLEAR);
  end
endmodule

// File: rtl/wlf_ptr.sv
module wlf_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = clr_i || adv_i;
    if (clr_i) begin
      ptr_d = '0;
    end else if (ptr_q == PTR_W'(DEPTH - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wlf_store.sv
module wlf_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0][DATA_W-1:0] slot_q;
  logic [DEPTH-1:0]             slot_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign slot_sel[g] = wr_en_i && (wr_ptr_i == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_sel[i]) begin
        slot_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/wlf_stat.sv
module wlf_stat
  import wlf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifo_op_e         op_i,
  input  logic             shift_busy_i,
  output logic [PTR_W-1:0] level_o,
  output logic             full_o,
  output logic             half_o,
  output logic             empty_o,
  output logic             avail_o,
  output logic             tx_idle_o,
  output logic             busy_err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    err_d  = err_q;
    cnt_en = 1'b0;
    case (op_i)
      OP_PUSH:   begin cnt_d = cnt_q + 1'b1; cnt_en = 1'b1; end
      OP_POP:    begin cnt_d = cnt_q - 1'b1; cnt_en = 1'b1; end
      OP_CLEAR:  begin cnt_d = '0; cnt_en = 1'b1; err_d = 1'b0; end
      OP_REFUSE: err_d = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign level_o    = cnt_q[PTR_W-1:0];
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign half_o     = (cnt_q >= CNT_W'(DEPTH / 2));
  assign empty_o    = (cnt_q == '0);
  assign avail_o    = !empty_o;
  assign tx_idle_o  = empty_o && !shift_busy_i;
  assign busy_err_o = err_q;
endmodule

// File: rtl/wrap_level_fifo.sv
module wrap_level_fifo
  import wlf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              shift_busy,
  output logic [DATA_W-1:0] pop_data,
  output logic [PTR_W-1:0]  level,
  output logic              full,
  output logic              half,
  output logic              empty,
  output logic              avail,
  output logic              tx_idle,
  output logic              busy_err
);
  fifo_op_e         op;
  logic             wr_en, rd_en, clr;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  wlf_ctrl u_ctrl (
    .push_i     (push),
    .pop_i      (pop),
    .soft_rst_i (soft_rst),
    .is_empty_i (empty),
    .is_full_i  (full),
    .op_o       (op),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .clr_o      (clr)
  );

  wlf_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk (clk), .rst_n (rst_n), .clr_i (clr), .adv_i (wr_en), .ptr_o (wr_ptr)
  );

  wlf_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk (clk), .rst_n (rst_n), .clr_i (clr), .adv_i (rd_en), .ptr_o (rd_ptr)
  );

  wlf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (push_data),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (pop_data)
  );

  wlf_stat #(.DEPTH(DEPTH)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op),
    .shift_busy_i (shift_busy),
    .level_o      (level),
    .full_o       (full),
    .half_o       (half),
    .empty_o      (empty),
    .avail_o      (avail),
    .tx_idle_o    (tx_idle),
    .busy_err_o   (busy_err)
  );
endmodule

// File: rtl/wlf_chk.sv
module wlf_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              push,
  input logic [DATA_W-1:0] push_data,
  input logic              pop,
  input logic              shift_busy,
  input logic [DATA_W-1:0] pop_data,
  input logic [PTR_W-1:0]  level,
  input logic              full,
  input logic              half,
  input logic              empty,
  input logic              avail,
  input logic              tx_idle,
  input logic              busy_err
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !soft_rst |=> full && $stable(pop_data));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !soft_rst |=> empty);

  p_both_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && push && pop && !soft_rst |=> $stable(level) && $stable(full));

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == '0) && avail && !empty);

  p_half_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full |-> half) and (empty |-> !half));

  p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> empty && !shift_busy);

  p_clean_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && empty |=> empty && !busy_err);

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !empty |=> busy_err && $stable(level) && $stable(full));

  p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err && !soft_rst |=> busy_err);
endmodule

bind wrap_level_fifo wlf_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wrap_level_fifo_tb.sv
`timescale 1ns/1ps
module wrap_level_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst, push, pop, shift_busy;
  logic [8:0] push_data;
  logic [8:0] pop_data;
  logic [2:0] level;
  logic       full, half, empty, avail, tx_idle, busy_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] exp_q[$];
  logic exp_err = 1'b0;
  event ev_sample;

  always #2.5 clk = ~clk;

  wrap_level_fifo u_dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // monitor: compares the head word whenever an accepted pop is driven
  always @(ev_sample) begin
    if (pop && !soft_rst && exp_q.size() > 0)
      chk("R2 pop_data order", int'(pop_data), int'(exp_q[0]));
  end

  task automatic status_chk();
    int n = exp_q.size();
    chk("R6 level", int'(level), n % 8);
    chk("R6 full", int'(full), int'(n == 8));
    chk("R7 half", int'(half), int'(n >= 4));
    chk("R4 empty", int'(empty), int'(n == 0));
    chk("R4 avail", int'(avail), int'(n != 0));
    chk("R8 tx_idle", int'(tx_idle), int'(n == 0 && !shift_busy));
    chk("R9 busy_err", int'(busy_err), int'(exp_err));
  endtask

  // driver: applies one cycle of stimulus and updates the expected queue
  task automatic step(input logic p, input logic [8:0] d, input logic q,
                      input logic s, input logic b);
    bit tp, tq;
    @(negedge clk);
    push = p; push_data = d; pop = q; soft_rst = s; shift_busy = b;
    #1;
    -> ev_sample;
    @(posedge clk);
    #1;
    if (s) begin
      if (exp_q.size() == 0) exp_err = 1'b0; else exp_err = 1'b1;
    end else begin
      tq = q && exp_q.size() > 0;
      tp = p && (exp_q.size() < 8 || tq);
      if (tq) void'(exp_q.pop_front());
      if (tp) exp_q.push_back(d);
    end
    status_chk();
  endtask

  initial begin
    int lv;
    rst_n = 1'b0; soft_rst = 0; push = 0; pop = 0; shift_busy = 0; push_data = '0;
    #12;
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset flags", int'({full, half, avail, busy_err}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: short burst in and out
    for (int i = 0; i < 3; i++) step(1, 9'(10 + i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);

    // R6/R7: fill to eight
    for (int i = 0; i < 8; i++) step(1, 9'(9'h100 | i), 0, 0, 0);
    chk("R6 wrap level at 8", int'(level), 0);
    chk("R6 full with avail", int'(full && avail), 1);
    // R3: push into full ignored
    step(1, 9'h0AA, 0, 0, 0);
    chk("R3 full push keeps head", int'(pop_data), 9'h100);
    chk("R3 full push keeps full", int'(full), 1);
    // R5: both on full keeps occupancy
    step(1, 9'h055, 1, 0, 0);
    chk("R5 both on full", int'(full), 1);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0);

    // R4: pop on empty ignored
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R4 empty pop stays empty", int'(empty), 1);

    // R5: both on empty accepts push only
    step(1, 9'h033, 1, 0, 0);
    chk("R5 both on empty", int'(level), 1);
    step(1, 9'h034, 0, 0, 0);
    step(1, 9'h035, 0, 0, 0);
    lv = int'(level);
    for (int i = 0; i < 5; i++) step(1, 9'(9'h040 + i), 1, 0, 0);
    chk("R5 both mid keeps level", int'(level), lv);

    // R8: shifter busy masks idle
    while (exp_q.size() > 0) step(0, 0, 1, 0, 1);
    chk("R8 idle masked by shifter", int'(tx_idle), 0);
    step(0, 0, 0, 0, 0);
    chk("R8 idle when shifter done", int'(tx_idle), 1);

    // R9: soft reset on loaded store refused
    step(1, 9'h1F0, 0, 0, 0);
    step(1, 9'h1F1, 0, 0, 0);
    step(1, 9'h1F2, 1, 1, 0);
    chk("R9 refused keeps level", int'(level), 2);
    chk("R9 err set", int'(busy_err), 1);
    // R10: stays until clean soft reset
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R10 err sticky", int'(busy_err), 1);
    step(1, 9'h0EE, 0, 1, 0);
    chk("R10 err cleared", int'(busy_err), 0);
    chk("R9 push ignored during clear", int'(empty), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule